// File: doc/BRIEF.md
# Display Register Window Decoder

This block sits behind a 4 KiB memory-mapped register window of a display controller and turns flat memory accesses into the operations that two register backends expect. Offsets 0x400–0x41F are forwarded, one byte at a time, to a legacy VGA I/O port backend at ports 0x3C0–0x3DF. Offsets 0x500–0x515 reach an extended-mode register file through an index/data pair: every access first writes a register index and then reads or writes the data register. An optional extension bank at 0x600–0x607 is held locally. It reports its own size and holds a framebuffer byte-order flag that can only be changed by writing one of two magic words.

Each request is held stable by the requester until the one-cycle acknowledge. The block runs the backend operations on consecutive cycles and acknowledges the request in the cycle after the last one. Offsets outside every sub-window are answered without touching either backend.

Top module: `dispwin_decoder`

## Requirements
- R1: After reset `rsp_ack`, `lg_valid`, `xm_valid` and `big_endian` are all 0.
- R2: A 1-byte access (`req_size`=0) at offset 0x400+o issues one legacy operation at port 0x3C0+o with `lg_write` equal to `req_write`. A write drives `req_wdata[7:0]`. A read returns `lg_rdata` in `rsp_rdata[7:0]` with the upper bits zero.
- R3: A 2-byte (`req_size`=1) or 4-byte (`req_size`=2) legacy access issues one byte operation per byte on consecutive cycles at ascending ports, starting at the low byte. Byte k uses `req_wdata[8k+7:8k]` and returns in `rsp_rdata[8k+7:8k]`.
- R4: A legacy access whose last byte lies beyond offset 0x41F issues no operation, reads zero and has no effect.
- R5: An access of any valid size at offset 0x500+o with o ≤ 0x15 issues two extended-mode operations. First comes an index write (`xm_sel`=0, `xm_write`=1, `xm_wdata`=o>>1). Then comes a data operation (`xm_sel`=1, `xm_write`=`req_write`, `xm_wdata`=`req_wdata[15:0]`). A read returns `xm_rdata` zero-extended.
- R6: A 4-byte read of bank offset 0 returns 8. A 4-byte read of bank offset 4 returns 0xBEBEBEBE while `big_endian` is 1 and 0x1E1E1E1E while it is 0.
- R7: A 4-byte write to bank offset 4 sets `big_endian` on 0xBEBEBEBE and clears it on 0x1E1E1E1E. Any other value leaves it unchanged. The new value shows in the cycle after the request is accepted.
- R8: Bank accesses that are not 4 bytes wide, or that target any offset other than 0 and 4, read zero and change nothing.
- R9: With `EXT_BANK_EN`=0 the range 0x600–0x607 is unmapped: reads return zero and magic writes leave `big_endian` at 0.
- R10: Offsets outside all sub-windows, and requests with `req_size`=3, read zero, change nothing and issue no backend operation.
- R11: `rsp_ack` is a one-cycle pulse in the cycle after the last backend operation, or in the cycle after acceptance when there is none. `rsp_rdata` is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until `rsp_ack` |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, little-endian bytes |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |
| lg_valid | output | 1 | Legacy byte operation this cycle |
| lg_write | output | 1 | Legacy operation is a write |
| lg_port | output | LEG_PORT_W | Legacy port number |
| lg_wdata | output | 8 | Legacy write byte |
| lg_rdata | input | 8 | Legacy read byte, sampled while `lg_valid` |
| xm_valid | output | 1 | Extended-mode operation this cycle |
| xm_sel | output | 1 | 0 = index register, 1 = data register |
| xm_write | output | 1 | Extended-mode operation is a write |
| xm_wdata | output | 16 | Index or data value |
| xm_rdata | input | 16 | Data register read value |
| big_endian | output | 1 | Framebuffer byte-order flag |

## Verification
Legacy accesses are tried at 1, 2 and 4 bytes at both ends of the port range. This separates a correct byte order and port increment from a swapped or non-advancing sequence. Accesses that straddle the window's end are tried as well, which exposes a decoder that checks only the start address. Extended-mode accesses at the first, a middle and the last register show whether the index is the halved offset and whether it precedes the data operation. The byte-order register is written with both magic words, with near-miss values and with the wrong width. A second instance without the bank receives the same traffic, which tells a disabled bank apart from one that is merely ignored.

// File: rtl/dispwin_pkg.sv
package dispwin_pkg;

    localparam int LEG_BASE   = 'h400;
    localparam int LEG_SPAN   = 32;
    localparam int LEG_PORT0  = 'h3C0;
    localparam int XM_BASE    = 'h500;
    localparam int XM_SPAN    = 22;
    localparam int BANK_BASE  = 'h600;
    localparam int BANK_SPAN  = 8;
    localparam int BANK_SIZE_OFF = 0;
    localparam int BANK_BO_OFF   = 4;
    localparam int OFF_W      = $clog2(LEG_SPAN);

    localparam logic [31:0] BE_MAGIC = 32'hBEBE_BEBE;
    localparam logic [31:0] LE_MAGIC = 32'h1E1E_1E1E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEG,
        ST_XIDX,
        ST_XDAT,
        ST_ACK
    } dw_state_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_LEG,
        RG_XM,
        RG_BANK
    } dw_region_e;

    typedef struct packed {
        dw_state_e        st;
        logic [1:0]       cnt;
        logic [1:0]       last;
        logic [OFF_W-1:0] off;
        logic             wr;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
    } dw_ctx_t;

endpackage

// File: rtl/dispwin_decode.sv
module dispwin_decode
    import dispwin_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter bit BANK_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dw_region_e        region,
    output logic [OFF_W-1:0]  off,
    output logic [1:0]        last
);
    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] lo;
    logic [EW-1:0] hi;
    logic          size_ok;
    logic          leg_hit;
    logic          xm_hit;
    logic          bank_hit;

    always_comb begin
        case (size)
            2'd0:    last = 2'd0;
            2'd1:    last = 2'd1;
            2'd2:    last = 2'd3;
            default: last = 2'd0;
        endcase
        size_ok = (size != 2'd3);
        lo      = {1'b0, addr};
        hi      = lo + EW'(last);
        leg_hit = size_ok && (lo >= EW'(LEG_BASE)) && (hi < EW'(LEG_BASE + LEG_SPAN));
        xm_hit  = size_ok && (lo >= EW'(XM_BASE))  && (hi < EW'(XM_BASE + XM_SPAN));
    end

    generate
        if (BANK_EN) begin : g_bank
            assign bank_hit = (lo >= EW'(BANK_BASE)) && (lo < EW'(BANK_BASE + BANK_SPAN));
        end else begin : g_nobank
            assign bank_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        region = RG_NONE;
        off    = '0;
        if (leg_hit) begin
            region = RG_LEG;
            off    = OFF_W'(addr - ADDR_W'(LEG_BASE));
        end else if (xm_hit) begin
            region = RG_XM;
            off    = OFF_W'(addr - ADDR_W'(XM_BASE));
        end else if (bank_hit) begin
            region = RG_BANK;
            off    = OFF_W'(addr - ADDR_W'(BANK_BASE));
        end
    end

endmodule

// File: rtl/dispwin_byteorder.sv
module dispwin_byteorder
    import dispwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        be
);
    logic be_d;
    logic be_q;

    always_comb begin
        be_d = be_q;
        if (wr_en && wr_data == BE_MAGIC) begin
            be_d = 1'b1;
        end else if (wr_en && wr_data == LE_MAGIC) begin
            be_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) be_q <= 1'b0;
        else        be_q <= be_d;
    end

    assign be = be_q;

    // R7
    byteorder_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_data != BE_MAGIC && wr_data != LE_MAGIC)) |=> $stable(be_q));

endmodule

// File: rtl/dispwin_decoder.sv
module dispwin_decoder
    import dispwin_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int LEG_PORT_W  = 10,
    parameter bit EXT_BANK_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic                  req_write,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_ack,
    output logic [31:0]           rsp_rdata,
    output logic                  lg_valid,
    output logic                  lg_write,
    output logic [LEG_PORT_W-1:0] lg_port,
    output logic [7:0]            lg_wdata,
    input  logic [7:0]            lg_rdata,
    output logic                  xm_valid,
    output logic                  xm_sel,
    output logic                  xm_write,
    output logic [15:0]           xm_wdata,
    input  logic [15:0]           xm_rdata,
    output logic                  big_endian
);
    dw_region_e       dec_region;
    logic [OFF_W-1:0] dec_off;
    logic [1:0]       dec_last;
    logic             bo_wr;
    logic             be;
    dw_ctx_t          ctx_d;
    dw_ctx_t          ctx_q;

    dispwin_decode #(
        .ADDR_W  (ADDR_W),
        .BANK_EN (EXT_BANK_EN)
    ) u_dec (
        .addr   (req_addr),
        .size   (req_size),
        .region (dec_region),
        .off    (dec_off),
        .last   (dec_last)
    );

    dispwin_byteorder u_bo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bo_wr),
        .wr_data (req_wdata),
        .be      (be)
    );

    always_comb begin
        ctx_d = ctx_q;
        bo_wr = 1'b0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.off   = dec_off;
                    ctx_d.last  = dec_last;
                    ctx_d.cnt   = 2'd0;
                    ctx_d.wr    = req_write;
                    ctx_d.wdata = req_wdata;
                    ctx_d.rdata = '0;
                    case (dec_region)
                        RG_LEG:  ctx_d.st = ST_LEG;
                        RG_XM:   ctx_d.st = ST_XIDX;
                        RG_BANK: begin
                            ctx_d.st = ST_ACK;
                            if (req_size == 2'd2) begin
                                if (dec_off == OFF_W'(BANK_SIZE_OFF)) begin
                                    ctx_d.rdata = 32'(BANK_SPAN);
                                end else if (dec_off == OFF_W'(BANK_BO_OFF)) begin
                                    ctx_d.rdata = be ? BE_MAGIC : LE_MAGIC;
                                    bo_wr       = req_write;
                                end
                            end
                        end
                        default: ctx_d.st = ST_ACK;
                    endcase
                end
            end
            ST_LEG: begin
                ctx_d.rdata = ctx_q.rdata | (32'(lg_rdata) << {ctx_q.cnt, 3'b000});
                if (ctx_q.cnt == ctx_q.last) ctx_d.st = ST_ACK;
                else                         ctx_d.cnt = ctx_q.cnt + 2'd1;
            end
            ST_XIDX: ctx_d.st = ST_XDAT;
            ST_XDAT: begin
                ctx_d.rdata = 32'(xm_rdata);
                ctx_d.st    = ST_ACK;
            end
            ST_ACK:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= ST_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign lg_valid   = (ctx_q.st == ST_LEG);
    assign lg_write   = ctx_q.wr;
    assign lg_port    = LEG_PORT_W'(LEG_PORT0) + LEG_PORT_W'(ctx_q.off) + LEG_PORT_W'(ctx_q.cnt);
    assign lg_wdata   = 8'(ctx_q.wdata >> {ctx_q.cnt, 3'b000});
    assign xm_valid   = (ctx_q.st == ST_XIDX) || (ctx_q.st == ST_XDAT);
    assign xm_sel     = (ctx_q.st == ST_XDAT);
    assign xm_write   = (ctx_q.st == ST_XIDX) ? 1'b1 : ctx_q.wr;
    assign xm_wdata   = (ctx_q.st == ST_XIDX) ? 16'(ctx_q.off >> 1) : ctx_q.wdata[15:0];
    assign rsp_ack    = (ctx_q.st == ST_ACK);
    assign rsp_rdata  = (rsp_ack && !ctx_q.wr) ? ctx_q.rdata : '0;
    assign big_endian = be;

    // R2
    lg_port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lg_valid |-> (lg_port >= LEG_PORT_W'(LEG_PORT0)) &&
                     (lg_port <  LEG_PORT_W'(LEG_PORT0 + LEG_SPAN)));

    // R3
    lg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_valid && $past(lg_valid)) |-> (lg_port == $past(lg_port) + LEG_PORT_W'(1)));

    // R5
    xm_idx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_valid && xm_sel) |-> $past(xm_valid && !xm_sel && xm_write));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack);

    // R11
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> !lg_valid && !xm_valid);

endmodule

// File: tb/dispwin_decoder_test.sv
module dispwin_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;

    logic        rsp_ack, nb_ack;
    logic [31:0] rsp_rdata, nb_rdata;
    logic        lg_valid, lg_write, nb_lg_valid, nb_lg_write;
    logic [9:0]  lg_port, nb_lg_port;
    logic [7:0]  lg_wdata, nb_lg_wdata, lg_rdata, nb_lg_rdata;
    logic        xm_valid, xm_sel, xm_write, nb_xm_valid, nb_xm_sel, nb_xm_write;
    logic [15:0] xm_wdata, nb_xm_wdata, xm_rdata;
    logic        big_endian, nb_big_endian;

    logic [3:0]  stub_idx = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_be  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign lg_rdata    = lg_port[7:0] ^ 8'h5A;
    assign nb_lg_rdata = nb_lg_port[7:0] ^ 8'h5A;
    assign xm_rdata    = xm_sel ? (16'hA500 | 16'(stub_idx)) : 16'h0000;

    always @(posedge clk) begin
        if (xm_valid && !xm_sel && xm_write) stub_idx <= xm_wdata[3:0];
    end

    dispwin_decoder #(.EXT_BANK_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .lg_valid(lg_valid), .lg_write(lg_write), .lg_port(lg_port),
        .lg_wdata(lg_wdata), .lg_rdata(lg_rdata),
        .xm_valid(xm_valid), .xm_sel(xm_sel), .xm_write(xm_write),
        .xm_wdata(xm_wdata), .xm_rdata(xm_rdata),
        .big_endian(big_endian)
    );

    dispwin_decoder #(.EXT_BANK_EN(1'b0)) uut_nb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_ack(nb_ack), .rsp_rdata(nb_rdata),
        .lg_valid(nb_lg_valid), .lg_write(nb_lg_write), .lg_port(nb_lg_port),
        .lg_wdata(nb_lg_wdata), .lg_rdata(nb_lg_rdata),
        .xm_valid(nb_xm_valid), .xm_sel(nb_xm_sel), .xm_write(nb_xm_write),
        .xm_wdata(nb_xm_wdata), .xm_rdata(xm_rdata),
        .big_endian(nb_big_endian)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_be;
        chk("R7", "big_endian", 32'(big_endian), 32'(exp_be));
        chk("R9", "nb big_endian", 32'(nb_big_endian), 32'h0);
    endtask

    // Drive at a negedge; returns at a negedge with the bus idle again.
    task automatic do_req(input int a, input int sz, input bit wr, input logic [31:0] wd,
                          input string rq);
        int nb;
        int region;   // 0 none, 1 legacy, 2 ext-mode, 3 bank
        logic [31:0] exp_rd;
        logic [31:0] exp_nb_rd;
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        region = 0;
        if (sz != 3 && a >= 'h400 && a + nb - 1 <= 'h41F)      region = 1;
        else if (sz != 3 && a >= 'h500 && a + nb - 1 <= 'h515) region = 2;
        else if (a >= 'h600 && a < 'h608)                      region = 3;
        exp_rd = '0;
        if (region == 3 && sz == 2 && a == 'h600) exp_rd = 32'd8;
        if (region == 3 && sz == 2 && a == 'h604) exp_rd = (exp_be != 0) ? 32'hBEBEBEBE : 32'h1E1E1E1E;

        req_valid = 1'b1;
        req_addr  = 12'(a);
        req_size  = 2'(sz);
        req_write = wr;
        req_wdata = wd;
        @(posedge clk);
        if (region == 3 && wr && sz == 2 && a == 'h604) begin
            if (wd == 32'hBEBEBEBE) exp_be = 1;
            if (wd == 32'h1E1E1E1E) exp_be = 0;
        end

        if (region == 1) begin
            for (int k = 0; k < nb; k++) begin
                @(negedge clk);
                chk(rq, "lg_valid", 32'(lg_valid), 32'h1);
                chk(rq, "lg_port", 32'(lg_port), 32'('h3C0 + a - 'h400 + k));
                chk(rq, "lg_write", 32'(lg_write), 32'(wr));
                if (wr) chk(rq, "lg_wdata", 32'(lg_wdata), 32'(wd[8*k +: 8]));
                chk(rq, "xm_valid", 32'(xm_valid), 32'h0);
                chk("R11", "early ack", 32'(rsp_ack), 32'h0);
                chk("R9", "nb lg_port", 32'(nb_lg_port), 32'(lg_port));
                chk_be();
                exp_rd = exp_rd | (32'((('h3C0 + a - 'h400 + k) & 'hFF) ^ 'h5A) << (8 * k));
            end
        end else if (region == 2) begin
            @(negedge clk);
            chk("R5", "idx valid", 32'(xm_valid), 32'h1);
            chk("R5", "idx sel", 32'(xm_sel), 32'h0);
            chk("R5", "idx write", 32'(xm_write), 32'h1);
            chk("R5", "idx value", 32'(xm_wdata), 32'((a - 'h500) >> 1));
            chk("R11", "early ack", 32'(rsp_ack), 32'h0);
            chk_be();
            @(negedge clk);
            chk("R5", "data valid", 32'(xm_valid), 32'h1);
            chk("R5", "data sel", 32'(xm_sel), 32'h1);
            chk("R5", "data write", 32'(xm_write), 32'(wr));
            if (wr) chk("R5", "data value", 32'(xm_wdata), 32'(wd[15:0]));
            chk("R11", "early ack", 32'(rsp_ack), 32'h0);
            chk_be();
            exp_rd = 32'h0000A500 | 32'((a - 'h500) >> 1);
        end

        if (wr) exp_rd = '0;
        exp_nb_rd = (region == 3) ? 32'h0 : exp_rd;

        @(negedge clk);
        chk("R11", "ack", 32'(rsp_ack), 32'h1);
        chk(rq, "rdata", rsp_rdata, exp_rd);
        chk("R11", "quiet lg", 32'(lg_valid), 32'h0);
        chk("R11", "quiet xm", 32'(xm_valid), 32'h0);
        chk("R9", "nb ack", 32'(nb_ack), 32'h1);
        chk("R9", "nb rdata", nb_rdata, exp_nb_rd);
        chk_be();
        req_valid = 1'b0;

        @(negedge clk);
        chk("R11", "ack pulse", 32'(rsp_ack), 32'h0);
        chk("R10", "idle lg", 32'(lg_valid), 32'h0);
        chk("R10", "idle xm", 32'(xm_valid), 32'h0);
        chk_be();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ack", 32'(rsp_ack), 32'h0);
        chk("R1", "lg_valid", 32'(lg_valid), 32'h0);
        chk("R1", "xm_valid", 32'(xm_valid), 32'h0);
        chk("R1", "big_endian", 32'(big_endian), 32'h0);

        // R2 single-byte legacy at both ends
        do_req('h400, 0, 1'b0, 32'h0, "R2");
        do_req('h41F, 0, 1'b1, 32'h0000_00C7, "R2");
        do_req('h41F, 0, 1'b0, 32'h0, "R2");
        // R3 multi-byte legacy
        do_req('h404, 1, 1'b1, 32'h0000_3A11, "R3");
        do_req('h414, 1, 1'b0, 32'h0, "R3");
        do_req('h408, 2, 1'b0, 32'h0, "R3");
        do_req('h41C, 2, 1'b1, 32'hDEAD_BEEF, "R3");
        // R4 straddling the end
        do_req('h41F, 1, 1'b0, 32'h0, "R4");
        do_req('h41E, 2, 1'b1, 32'h1234_5678, "R4");
        // R5 extended-mode
        do_req('h502, 1, 1'b1, 32'h0000_0320, "R5");
        do_req('h502, 1, 1'b0, 32'h0, "R5");
        do_req('h514, 1, 1'b0, 32'h0, "R5");
        do_req('h50A, 0, 1'b1, 32'h0000_00FF, "R5");
        do_req('h500, 2, 1'b0, 32'h0, "R5");
        do_req('h516, 0, 1'b0, 32'h0, "R10");
        // R6 bank reads
        do_req('h600, 2, 1'b0, 32'h0, "R6");
        do_req('h604, 2, 1'b0, 32'h0, "R6");
        // R7 magic writes
        do_req('h604, 2, 1'b1, 32'hBEBE_BEBE, "R7");
        do_req('h604, 2, 1'b0, 32'h0, "R6");
        do_req('h604, 2, 1'b1, 32'h1234_5678, "R7");
        do_req('h604, 2, 1'b1, 32'h1E1E_1E1E, "R7");
        do_req('h604, 2, 1'b0, 32'h0, "R6");
        do_req('h604, 2, 1'b1, 32'hBEBE_BEBF, "R7");
        do_req('h604, 2, 1'b1, 32'hBEBE_BEBE, "R7");
        // R8 wrong width / offset
        do_req('h604, 0, 1'b1, 32'h1E1E_1E1E, "R8");
        do_req('h604, 1, 1'b0, 32'h0, "R8");
        do_req('h602, 2, 1'b0, 32'h0, "R8");
        do_req('h600, 2, 1'b1, 32'h1E1E_1E1E, "R8");
        do_req('h604, 2, 1'b0, 32'h0, "R6");
        // R10 unmapped
        do_req('h000, 2, 1'b0, 32'h0, "R10");
        do_req('hFFC, 2, 1'b1, 32'hBEBE_BEBE, "R10");
        do_req('h400, 3, 1'b0, 32'h0, "R10");
        do_req('h608, 2, 1'b0, 32'h0, "R10");
        // R9 is checked on uut_nb in every request above; one final clear
        do_req('h604, 2, 1'b1, 32'h1E1E_1E1E, "R9");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule